// File: doc/BRIEF.md
# CPU Bus Cycle Classifier

This block watches the control strobes, data bus and address bus of an 8-bit microprocessor, taking one sample per clock. It sorts every sample into one of seven cycle kinds: none, memory read, memory write, I/O read, I/O write, opcode fetch or interrupt acknowledge. A prioritised decode looks at all the strobes together to pick the kind.

The block follows changes in the kind, not edges on any single strobe. A move from idle into an active kind raises a one-clock begin event and latches the address. A move from an active kind back to idle raises a one-clock end event. That event reports the kind that just finished and the last data byte seen during it.

A jump straight from one active kind to a different active kind is a protocol fault. It raises a one-clock fault event and discards the pending cycle, so no end event is reported for it. The block expects inputs that are already synchronous to its clock. It is a passive observer and never drives the bus.

Top module: `cpu_bus_tracker`

## Requirements
- R1: With `mreq_n` low and `rd_n` low, the kind is fetch (5) when `m1_n` is low and memory read (1) when `m1_n` is high. With `mreq_n` low, `rd_n` high and `wr_n` low, the kind is memory write (2). With `mreq_n` low and both `rd_n` and `wr_n` high, the kind is none (0), whatever `iorq_n` is.
- R2: With `mreq_n` high and `iorq_n` low, the kind is interrupt acknowledge (6) when `m1_n` is low. Otherwise it is I/O read (3) when `rd_n` is low, and I/O write (4) when only `wr_n` is low.
- R3: The memory request check takes priority over the I/O request check. When both request strobes are low and `rd_n` is low, the kind is memory read or fetch. Every strobe combination not covered by R1 or R2 gives none (0). `kind_now` shows the decode of the current inputs combinationally.
- R4: When the sampled kind changes from none to an active kind, `begin_pulse` is high for the clock after that sample, and `begin_addr` then holds the address bus value from that sample.
- R5: When the sampled kind changes from an active kind to none, `end_pulse` is high for the clock after that sample, and `end_kind` gives the kind that ended. This holds only if no fault occurred since that cycle's begin.
- R6: While the kind is active, the data byte is recaptured on every sample. `end_data` reports the byte from the last active sample before the change to none.
- R7: A direct change between two different active kinds raises `fault_pulse` for one clock. No end pulse is given when the kind later returns to none, until a new begin occurs.
- R8: Every event pulse lasts exactly one clock, and at most one event is high at a time. A sample with the same kind as the previous sample produces no event.
- R9: A synchronous active-high `rst` clears all event pulses, `begin_addr`, `end_kind` and `end_data`, and sets the remembered previous kind to none. An active sample right after reset therefore gives a begin event, and a return to none right after reset gives no end event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| m1_n | input | 1 | First-machine-cycle strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| data_in | input | DATA_W (8) | Sampled data bus |
| addr_in | input | ADDR_W (16) | Sampled address bus |
| kind_now | output | 3 | Combinational kind of the current sample |
| begin_pulse | output | 1 | One-clock cycle-begin event |
| begin_addr | output | ADDR_W (16) | Address latched at the last begin |
| end_pulse | output | 1 | One-clock cycle-end event |
| end_kind | output | 3 | Kind of the cycle that ended |
| end_data | output | DATA_W (8) | Last data byte of the cycle that ended |
| fault_pulse | output | 1 | One-clock illegal-transition event |

## Verification
A wrong remembered previous kind shows within one clock. It appears as a missing or extra begin, end or fault pulse on the sample after the next change of kind, and it can also show as a pulse on a sample with no change. A stale data register shows only at the next end event, as a wrong `end_data`. The tests therefore change the data byte inside a cycle. A clean-cycle flag that stays set after a fault shows as an end pulse that should not appear once the bus returns to idle. The tests provoke this case with double hops and with a reset in mid-cycle.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_FETCH = 3'd5,
    CYC_INTA  = 3'd6
  } cyc_e;

  // Prioritised strobe decode; memory request is examined first.
  function automatic cyc_e classify(input logic m1_n, input logic rd_n,
                                    input logic wr_n, input logic mreq_n,
                                    input logic iorq_n);
    cyc_e k;
    k = CYC_NONE;
    if (!mreq_n) begin
      if (!rd_n)      k = m1_n ? CYC_MRD : CYC_FETCH;
      else if (!wr_n) k = CYC_MWR;
    end else if (!iorq_n) begin
      if (!m1_n)      k = CYC_INTA;
      else if (!rd_n) k = CYC_IORD;
      else if (!wr_n) k = CYC_IOWR;
    end
    return k;
  endfunction

  function automatic logic is_active(input cyc_e k);
    return k != CYC_NONE;
  endfunction

endpackage

// File: rtl/cbt_decode.sv
module cbt_decode
  import cpu_bus_pkg::*;
(
  input  logic m1_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic mreq_n,
  input  logic iorq_n,
  output cyc_e kind
);
  always_comb kind = classify(m1_n, rd_n, wr_n, mreq_n, iorq_n);
endmodule

// File: rtl/cbt_edge.sv
module cbt_edge
  import cpu_bus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cyc_e kind,
  output cyc_e kind_prev,
  output logic ev_begin,
  output logic ev_finish,
  output logic ev_hop
);
  cyc_e prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= CYC_NONE;
    else     prev_q <= kind;
  end

  logic changed;
  always_comb begin
    changed   = (kind != prev_q);
    ev_begin  = changed && !is_active(prev_q);
    ev_finish = changed && !is_active(kind);
    ev_hop    = changed && is_active(prev_q) && is_active(kind);
  end

  assign kind_prev = prev_q;
endmodule

// File: rtl/cbt_capture.sv
module cbt_capture
  import cpu_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              kind,
  input  cyc_e              kind_prev,
  input  logic              ev_begin,
  input  logic              ev_finish,
  input  logic              ev_hop,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cycle_clean,
  output logic              begin_pulse,
  output logic [ADDR_W-1:0] begin_addr,
  output logic              end_pulse,
  output logic [2:0]        end_kind,
  output logic [DATA_W-1:0] end_data,
  output logic              fault_pulse
);
  logic [DATA_W-1:0] data_q;
  logic              clean_q;
  logic              report_end;

  assign report_end  = ev_finish && clean_q;
  assign cycle_clean = clean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= '0;
      clean_q     <= 1'b0;
      begin_pulse <= 1'b0;
      end_pulse   <= 1'b0;
      fault_pulse <= 1'b0;
      begin_addr  <= '0;
      end_kind    <= '0;
      end_data    <= '0;
    end else begin
      begin_pulse <= ev_begin;
      end_pulse   <= report_end;
      fault_pulse <= ev_hop;
      if (is_active(kind)) data_q <= data_in;
      if (ev_begin) begin
        begin_addr <= addr_in;
        clean_q    <= 1'b1;
      end else if (ev_hop || ev_finish) begin
        clean_q    <= 1'b0;
      end
      if (report_end) begin
        end_kind <= kind_prev;
        end_data <= data_q;
      end
    end
  end
endmodule

// File: rtl/cpu_bus_tracker.sv
module cpu_bus_tracker
  import cpu_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [2:0]        kind_now,
  output logic              begin_pulse,
  output logic [ADDR_W-1:0] begin_addr,
  output logic              end_pulse,
  output logic [2:0]        end_kind,
  output logic [DATA_W-1:0] end_data,
  output logic              fault_pulse
);
  cyc_e kind_w;
  cyc_e kind_prev;
  logic ev_begin, ev_finish, ev_hop, cycle_clean;

  cbt_decode u_decode (
    .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .kind(kind_w)
  );

  cbt_edge u_edge (
    .clk(clk), .rst(rst), .kind(kind_w), .kind_prev(kind_prev),
    .ev_begin(ev_begin), .ev_finish(ev_finish), .ev_hop(ev_hop)
  );

  cbt_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst(rst), .kind(kind_w), .kind_prev(kind_prev),
    .ev_begin(ev_begin), .ev_finish(ev_finish), .ev_hop(ev_hop),
    .data_in(data_in), .addr_in(addr_in), .cycle_clean(cycle_clean),
    .begin_pulse(begin_pulse), .begin_addr(begin_addr),
    .end_pulse(end_pulse), .end_kind(end_kind), .end_data(end_data),
    .fault_pulse(fault_pulse)
  );

  assign kind_now = kind_w;
endmodule

// File: rtl/cpu_bus_tracker_chk.sv
module cpu_bus_tracker_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              m1_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [2:0]        kind_w,
  input logic [2:0]        kind_prev,
  input logic              begin_pulse,
  input logic [ADDR_W-1:0] begin_addr,
  input logic              end_pulse,
  input logic [2:0]        end_kind,
  input logic              fault_pulse
);
  p_fetch_decode_r1: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rd_n && !m1_n) |-> kind_w == 3'd5);

  p_inta_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (mreq_n && !iorq_n && !m1_n) |-> kind_w == 3'd6);

  p_mem_priority_r3: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !iorq_n && !rd_n && m1_n) |-> kind_w == 3'd1);

  p_begin_source_r4: assert property (@(posedge clk) disable iff (rst)
    begin_pulse |-> ($past(kind_prev) == 3'd0 && $past(kind_w) != 3'd0
                     && begin_addr == $past(addr_in)));

  p_end_source_r5: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> (end_kind != 3'd0 && $past(kind_w) == 3'd0
                   && end_kind == $past(kind_prev)));

  p_hop_source_r7: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> ($past(kind_w) != 3'd0 && $past(kind_prev) != 3'd0
                     && $past(kind_w) != $past(kind_prev)));

  p_single_event_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({begin_pulse, end_pulse, fault_pulse}));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (kind_w == kind_prev) |=> !(begin_pulse || end_pulse || fault_pulse));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(begin_pulse || end_pulse || fault_pulse));
endmodule

bind cpu_bus_tracker cpu_bus_tracker_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cpu_bus_tracker_bench.sv
module cpu_bus_tracker_bench;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int NV = 26;
  localparam int VW = 46;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
  logic [DW-1:0] data_in = '0;
  logic [AW-1:0] addr_in = '0;
  logic [2:0]    kind_now;
  logic          begin_pulse, end_pulse, fault_pulse;
  logic [AW-1:0] begin_addr;
  logic [2:0]    end_kind;
  logic [DW-1:0] end_data;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cpu_bus_tracker u_cpu_bus_tracker (
    .clk(clk), .rst(rst), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .data_in(data_in), .addr_in(addr_in),
    .kind_now(kind_now), .begin_pulse(begin_pulse), .begin_addr(begin_addr),
    .end_pulse(end_pulse), .end_kind(end_kind), .end_data(end_data),
    .fault_pulse(fault_pulse)
  );

  // strobes {m1,rd,wr,mreq,iorq} | data | addr | kind | b e f | end kind | end data
  localparam logic [VW-1:0] TBL [NV] = '{
    {5'b00101, 8'h3E, 16'h0100, 3'd5, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b00101, 8'h3E, 16'h0100, 3'd5, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'hFF, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd5, 8'h3E},
    {5'b10101, 8'h42, 16'h0101, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b10101, 8'h43, 16'h0102, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'hFF, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 8'h43},
    {5'b11001, 8'h99, 16'h8000, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd2, 8'h99},
    {5'b10110, 8'h12, 16'h0010, 3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd3, 8'h12},
    {5'b11010, 8'h34, 16'h0020, 3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd4, 8'h34},
    {5'b01110, 8'hFF, 16'h0038, 3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd6, 8'hFF},
    {5'b10100, 8'h55, 16'h1234, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11100, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 8'h55},
    {5'b00110, 8'hE7, 16'h00FF, 3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b10110, 8'h01, 16'h00FF, 3'd3, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b10101, 8'h77, 16'h2000, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11001, 8'h78, 16'h2000, 3'd2, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00},
    {5'b10101, 8'h79, 16'h2000, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b10001, 8'hA5, 16'h3000, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00},
    {5'b11111, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 8'hA5},
    {5'b01100, 8'h00, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s, input logic [DW-1:0] d,
                       input logic [AW-1:0] a);
    {m1_n, rd_n, wr_n, mreq_n, iorq_n} = s;
    data_in = d;
    addr_in = a;
  endtask

  task automatic check_events(input string req, input logic b, input logic e,
                              input logic f);
    check({req, " begin"}, 32'(begin_pulse), 32'(b));
    check({req, " end"},   32'(end_pulse),   32'(e));
    check({req, " fault"}, 32'(fault_pulse), 32'(f));
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9: reset state
    check_events("R9 reset", 1'b0, 1'b0, 1'b0);
    check("R9 begin_addr", 32'(begin_addr), 32'h0);
    check("R9 end_kind", 32'(end_kind), 32'h0);
    check("R9 end_data", 32'(end_data), 32'h0);
    rst = 1'b0;

    // Vector walk: R1 R2 R3 decode, R4 begin, R5 R6 end, R7 hop, R8 quiet
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      drive(v[45:41], v[40:33], v[32:17]);
      #1;
      check($sformatf("R1/R2/R3 kind v%0d", i), 32'(kind_now), 32'(v[16:14]));
      @(negedge clk);
      check_events($sformatf("R4/R5/R7/R8 v%0d", i), v[13], v[12], v[11]);
      if (v[13]) check($sformatf("R4 addr v%0d", i), 32'(begin_addr), 32'(v[32:17]));
      if (v[12]) begin
        check($sformatf("R5 end_kind v%0d", i), 32'(end_kind), 32'(v[10:8]));
        check($sformatf("R6 end_data v%0d", i), 32'(end_data), 32'(v[7:0]));
      end
    end

    // R8: pulse lasts one clock only while a kind is held
    drive(5'b11001, 8'h5A, 16'h4444);
    @(negedge clk);
    check_events("R8 begin first", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_events("R8 held", 1'b0, 1'b0, 1'b0);

    // R9: reset in mid-cycle, active kind held through release
    rst = 1'b1;
    @(negedge clk);
    check_events("R9 in reset", 1'b0, 1'b0, 1'b0);
    check("R9 addr cleared", 32'(begin_addr), 32'h0);
    rst = 1'b0;
    drive(5'b10101, 8'h11, 16'h4000);
    @(negedge clk);
    check_events("R9 begin after reset", 1'b1, 1'b0, 1'b0);
    check("R9 addr after reset", 32'(begin_addr), 32'h4000);
    drive(5'b11111, 8'h00, 16'h0000);
    @(negedge clk);
    check_events("R5 end after reset", 1'b0, 1'b1, 1'b0);
    check("R6 end_data after reset", 32'(end_data), 32'h11);

    // R9: reset during a cycle, release at idle gives no end
    drive(5'b10110, 8'h22, 16'h0033);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(5'b11111, 8'h00, 16'h0000);
    @(negedge clk);
    check_events("R9 no end after reset", 1'b0, 1'b0, 1'b0);
    check("R9 end_data kept clear", 32'(end_data), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule